// File: doc/BRIEF.md
# RS485 Driver-Enable Direction Sequencer

This block sits next to a UART transmitter that gives no event when its last bit has left the line. It owns the driver-enable line (`de_o`) of an RS485 transceiver. It turns the bus around to transmit before any data goes out and holds it there until the final stop bit is gone. It then releases the bus after an optional guard time. Transmit requests from the host side arrive on `tx_req_i`. The block answers each one with a one-cycle `tx_start_o` strobe to the UART at the moment the line direction allows it.

The only completion information available is the host buffer's empty flag and the UART FIFO's empty flag. The block therefore polls the FIFO flag once per character time. It accepts drain only when the flag reads empty on two polls in a row, which allows one full character for the shift register to finish. The character time comes from the frame format and baud rate through a multi-cycle divider. The pre-send and post-send guard delays are given in milliseconds and are counted in cycles of a parameterised clock.

Top module: `rs485_de_seq`

## Requirements
- R1: After reset the sequencer is in the receive state with `de_o` low and `tx_start_o` low.
- R2: A request in the receive state sets `de_o` to `de_on_send_i` on the next edge. With a zero pre-send delay, `tx_start_o` pulses on that same edge. Otherwise it pulses exactly `pre_dly_ms_i`×(CLK_HZ/1000) cycles later.
- R3: A request while the pre-send delay runs is ignored: no extra strobe, and the delay is not restarted.
- R4: A request while sending gives one `tx_start_o` pulse on the next edge, leaves `de_o` unchanged and cancels any running drain poll.
- R5: A request during the post-send delay returns to sending with a strobe and no change of `de_o`. If it coincides with the delay's expiry, the full pre-send sequence of R2 runs instead.
- R6: While sending, with `buf_empty_i` high and no divide in progress, a poll starts with a period of one character time. A poll tick that finds `buf_empty_i` low stops polling and leaves the state and `de_o` as they are.
- R7: Drain is accepted only on a poll tick where `fifo_empty_i` is high and was also high on the previous tick of the same poll run.
- R8: On drain with a zero post-send delay, `de_o` takes `de_after_send_i` and the block enters receive on that edge. Otherwise `de_o` takes that level `post_dly_ms_i`×(CLK_HZ/1000) cycles later.
- R9: Bits per character are 7 + `data_bits_i`, where codes 0..3 stand for 5..8 data bits. One more bit is added for `two_stop_i` and one more for `parity_en_i`.
- R10: Character time is floor(bits×CLK_HZ/`baud_i`) cycles, with a minimum of 1. It is recomputed whenever the baud rate or frame fields change.
- R11: While `en_i` is low, `de_o` is low, both timers are cleared and the state is receive. Each request then gives a `tx_start_o` pulse on the next edge.
- R12: On the first enabled cycle after `en_i` was low, the block enters receive with `de_o` equal to `de_after_send_i`. Requests in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Direction control enable |
| de_on_send_i | input | 1 | DE level while transmitting |
| de_after_send_i | input | 1 | DE level when released to receive |
| pre_dly_ms_i | input | DLY_W | Delay from DE assertion to first start, ms |
| post_dly_ms_i | input | DLY_W | Delay from drain to DE release, ms |
| baud_i | input | BAUD_W | Baud rate in bits per second |
| data_bits_i | input | 2 | Data bits code, 0..3 = 5..8 |
| two_stop_i | input | 1 | Two stop bits |
| parity_en_i | input | 1 | Parity bit present |
| tx_req_i | input | 1 | Transmit request pulse |
| buf_empty_i | input | 1 | Host transmit buffer empty |
| fifo_empty_i | input | 1 | UART transmit FIFO empty flag |
| de_o | output | 1 | Transceiver driver enable |
| tx_start_o | output | 1 | One-cycle start strobe to the UART |

## Verification
A wrong state has a narrow footprint at the ports. A sequencer stuck in sending shows up as a DE that never falls. A stale pre-send delay shows up as a missing or late `tx_start_o`. A drain accepted on the first empty tick drops DE one character period early, so the bench compares `de_o` and `tx_start_o` every cycle against an independent model and sees a difference within a single clock. Frame-format mistakes move the release edge by whole multiples of the bit time. They are caught by checking DE on both sides of the expected drain cycle for several formats.

// File: rtl/rs485_de_pkg.sv
package rs485_de_pkg;
  typedef enum logic [1:0] {
    ST_RX    = 2'd0,
    ST_PRE   = 2'd1,
    ST_SEND  = 2'd2,
    ST_AFTER = 2'd3
  } dir_state_e;
endpackage

// File: rtl/rs485_char_time.sv
module rs485_char_time #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD_W = 24,
  parameter int NUM_W  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic [1:0]        data_bits_i,
  input  logic              two_stop_i,
  input  logic              parity_en_i,
  output logic [NUM_W-1:0]  char_cyc_o,
  output logic              busy_o
);
  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam int CFG_W  = BAUD_W + 4;

  logic [CFG_W-1:0]  cfg, cfg_q;
  logic              valid_q, launch;
  logic [3:0]        bits;
  logic [NUM_W-1:0]  numer, quo_q, quo_d;
  logic [BAUD_W-1:0] rem_q, rem_d, baud_q;
  logic [BAUD_W:0]   rem_sh;
  logic              fits;
  logic [STEP_W-1:0] step_q;

  assign cfg    = {baud_i, data_bits_i, two_stop_i, parity_en_i};
  assign launch = !valid_q || (cfg != cfg_q);
  assign bits   = 4'd7 + {2'b0, data_bits_i} + {3'b0, two_stop_i} + {3'b0, parity_en_i};
  assign numer  = NUM_W'(bits) * NUM_W'(CLK_HZ);

  // restoring shift-subtract, one quotient bit per cycle
  assign rem_sh = {rem_q, quo_q[NUM_W-1]};
  assign fits   = rem_sh >= {1'b0, baud_q};
  assign rem_d  = fits ? BAUD_W'(rem_sh - {1'b0, baud_q}) : rem_sh[BAUD_W-1:0];
  assign quo_d  = {quo_q[NUM_W-2:0], fits};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      cfg_q      <= '0;
      baud_q     <= '0;
      quo_q      <= '0;
      rem_q      <= '0;
      step_q     <= '0;
      char_cyc_o <= NUM_W'(1);
    end else if (launch) begin
      valid_q <= 1'b1;
      cfg_q   <= cfg;
      baud_q  <= baud_i;
      quo_q   <= numer;
      rem_q   <= '0;
      step_q  <= STEP_W'(NUM_W);
    end else if (step_q != '0) begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      step_q <= step_q - 1'b1;
      if (step_q == STEP_W'(1)) char_cyc_o <= (quo_d == '0) ? NUM_W'(1) : quo_d;
    end
  end

  assign busy_o = launch || (step_q != '0);
endmodule

// File: rtl/rs485_down_timer.sv
module rs485_down_timer #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         cancel_i,
  output logic         expire_o,
  output logic         run_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cancel_i)       cnt_q <= '0;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == W'(1));
  assign run_o    = (cnt_q != '0);
endmodule

// File: rtl/rs485_de_seq.sv
module rs485_de_seq
  import rs485_de_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD_W = 24,
  parameter int DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              de_on_send_i,
  input  logic              de_after_send_i,
  input  logic [DLY_W-1:0]  pre_dly_ms_i,
  input  logic [DLY_W-1:0]  post_dly_ms_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic [1:0]        data_bits_i,
  input  logic              two_stop_i,
  input  logic              parity_en_i,
  input  logic              tx_req_i,
  input  logic              buf_empty_i,
  input  logic              fifo_empty_i,
  output logic              de_o,
  output logic              tx_start_o
);
  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int NUM_W      = $clog2(CLK_HZ) + 4;
  localparam int DLY_CNT_W  = DLY_W + $clog2(CYC_PER_MS + 1);
  localparam int CNT_W      = (NUM_W > DLY_CNT_W) ? NUM_W : DLY_CNT_W;

  dir_state_e       state_q, state_d;
  logic             de_q, de_d, start_q, start_d, seen_q, seen_d, en_q;
  logic [NUM_W-1:0] char_cyc;
  logic             div_busy;
  logic [CNT_W-1:0] pre_cyc, post_cyc, dly_val;
  logic             dly_load, dly_cancel, dly_expire, dly_run;
  logic             poll_load, poll_cancel, poll_tick, poll_run;
  logic             go_seq, drained;

  assign pre_cyc  = CNT_W'(pre_dly_ms_i) * CNT_W'(CYC_PER_MS);
  assign post_cyc = CNT_W'(post_dly_ms_i) * CNT_W'(CYC_PER_MS);

  rs485_char_time #(.CLK_HZ(CLK_HZ), .BAUD_W(BAUD_W), .NUM_W(NUM_W)) u_char_time (
    .clk_i, .rst_ni, .baud_i, .data_bits_i, .two_stop_i, .parity_en_i,
    .char_cyc_o (char_cyc),
    .busy_o     (div_busy)
  );

  rs485_down_timer #(.W(CNT_W)) u_dly_timer (
    .clk_i, .rst_ni,
    .load_i   (dly_load),
    .val_i    (dly_val),
    .cancel_i (dly_cancel),
    .expire_o (dly_expire),
    .run_o    (dly_run)
  );

  rs485_down_timer #(.W(CNT_W)) u_poll_timer (
    .clk_i, .rst_ni,
    .load_i   (poll_load),
    .val_i    (CNT_W'(char_cyc)),
    .cancel_i (poll_cancel),
    .expire_o (poll_tick),
    .run_o    (poll_run)
  );

  always_comb begin
    state_d     = state_q;
    de_d        = de_q;
    start_d     = 1'b0;
    seen_d      = seen_q;
    dly_load    = 1'b0;
    dly_val     = pre_cyc;
    dly_cancel  = 1'b0;
    poll_load   = 1'b0;
    poll_cancel = 1'b0;
    go_seq      = 1'b0;
    drained     = 1'b0;
    if (!en_i) begin
      state_d     = ST_RX;
      de_d        = 1'b0;
      start_d     = tx_req_i;
      dly_cancel  = 1'b1;
      poll_cancel = 1'b1;
    end else if (!en_q) begin
      state_d     = ST_RX;
      de_d        = de_after_send_i;
      dly_cancel  = 1'b1;
      poll_cancel = 1'b1;
    end else begin
      unique case (state_q)
        ST_RX:  go_seq = tx_req_i;
        ST_PRE: if (dly_expire) begin
          state_d = ST_SEND;
          start_d = 1'b1;
        end
        ST_SEND: begin
          if (tx_req_i) begin
            start_d     = 1'b1;
            poll_cancel = 1'b1;
          end else if (poll_tick) begin
            if (!buf_empty_i) poll_cancel = 1'b1;
            else if (fifo_empty_i && seen_q) begin
              poll_cancel = 1'b1;
              drained     = 1'b1;
            end else begin
              seen_d    = fifo_empty_i;
              poll_load = 1'b1;
            end
          end else if (!poll_run && buf_empty_i && !div_busy) begin
            seen_d    = 1'b0;
            poll_load = 1'b1;
          end
        end
        ST_AFTER: begin
          if (tx_req_i && dly_expire) go_seq = 1'b1;
          else if (tx_req_i) begin
            state_d    = ST_SEND;
            start_d    = 1'b1;
            dly_cancel = 1'b1;
          end else if (dly_expire) begin
            state_d = ST_RX;
            de_d    = de_after_send_i;
          end
        end
        default: state_d = ST_RX;
      endcase
      if (go_seq) begin
        de_d = de_on_send_i;
        if (pre_dly_ms_i == '0) begin
          state_d = ST_SEND;
          start_d = 1'b1;
        end else begin
          state_d  = ST_PRE;
          dly_load = 1'b1;
        end
      end
      if (drained) begin
        if (post_dly_ms_i == '0) begin
          state_d = ST_RX;
          de_d    = de_after_send_i;
        end else begin
          state_d  = ST_AFTER;
          dly_val  = post_cyc;
          dly_load = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RX;
      de_q    <= 1'b0;
      start_q <= 1'b0;
      seen_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      de_q    <= de_d;
      start_q <= start_d;
      seen_q  <= seen_d;
      en_q    <= en_i;
    end
  end

  assign de_o       = de_q;
  assign tx_start_o = start_q;

  logic unused_run;
  assign unused_run = dly_run;
endmodule

// File: rtl/rs485_de_seq_chk.sv
module rs485_de_seq_chk
  import rs485_de_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       de_o,
  input logic       tx_start_o,
  input dir_state_e state_i,
  input logic       dly_exp_i,
  input logic       poll_run_i,
  input logic       div_busy_i
);
  // R11: disabled forces DE low and receive state
  a_r11_off_de_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !de_o);
  a_r11_off_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_i == ST_RX);
  // R3: no strobe while the pre-send delay is still counting
  a_r3_pre_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_i == ST_PRE && !dly_exp_i) |=> !tx_start_o);
  // R4: DE holds while sending continues
  a_r4_send_de_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SEND && $past(state_i) == ST_SEND) |-> $stable(de_o));
  // R5: DE holds through the post-send delay
  a_r5_after_de_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_AFTER && $past(state_i) == ST_AFTER) |-> $stable(de_o));
  // R6: a poll run never begins during a divide
  a_r6_no_poll_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(poll_run_i) |-> !$past(div_busy_i));
endmodule

bind rs485_de_seq rs485_de_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .de_o       (de_o),
  .tx_start_o (tx_start_o),
  .state_i    (state_q),
  .dly_exp_i  (dly_expire),
  .poll_run_i (poll_run),
  .div_busy_i (div_busy)
);

// File: tb/rs485_de_seq_bench.sv
module rs485_de_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 200_000;
  localparam int CYC_MS     = CLK_HZ / 1000;
  localparam int BAUD_W     = 24;
  localparam int DLY_W      = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 0, de_on = 1, de_after = 0;
  logic [DLY_W-1:0] pre_ms = 1, post_ms = 1;
  logic [BAUD_W-1:0] baud = 20_000;
  logic [1:0] dbits = 2'd3;
  logic two_stop = 0, par_en = 0, tx_req = 0, buf_empty = 1, fifo_empty = 1;
  logic de_o, tx_start_o;

  int checks = 0, errors = 0, starts = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rs485_de_seq #(.CLK_HZ(CLK_HZ), .BAUD_W(BAUD_W), .DLY_W(DLY_W)) u_rs485_de_seq (
    .clk_i, .rst_ni, .en_i,
    .de_on_send_i (de_on), .de_after_send_i (de_after),
    .pre_dly_ms_i (pre_ms), .post_dly_ms_i (post_ms),
    .baud_i (baud), .data_bits_i (dbits), .two_stop_i (two_stop), .parity_en_i (par_en),
    .tx_req_i (tx_req), .buf_empty_i (buf_empty), .fifo_empty_i (fifo_empty),
    .de_o, .tx_start_o
  );

  // behavioural reference: 0 rx, 1 pre, 2 send, 3 after
  int  m_st, m_d, m_p;
  bit  m_de, m_start, m_seen, m_en;

  function automatic int char_cycles();
    int b = 7 + int'(dbits) + int'(two_stop) + int'(par_en);
    int c = (b * CLK_HZ) / int'(baud);
    return (c < 1) ? 1 : c;
  endfunction

  task automatic m_begin();
    m_de = de_on;
    if (pre_ms == 0) begin m_st = 2; m_start = 1; end
    else begin m_st = 1; m_d = int'(pre_ms) * CYC_MS; end
  endtask

  task automatic m_drain();
    if (post_ms == 0) begin m_st = 0; m_de = de_after; end
    else begin m_st = 3; m_d = int'(post_ms) * CYC_MS; end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_de = 0; m_start = 0; m_d = 0; m_p = 0; m_seen = 0; m_en = 0;
    end else begin
      bit dt, pt;
      dt = (m_d == 1); pt = (m_p == 1);
      m_start = 0;
      if (m_d > 0) m_d--;
      if (m_p > 0) m_p--;
      if (!en_i) begin
        m_st = 0; m_de = 0; m_start = tx_req; m_d = 0; m_p = 0;
      end else if (!m_en) begin
        m_st = 0; m_de = de_after; m_d = 0; m_p = 0;
      end else begin
        case (m_st)
          0: if (tx_req) m_begin();
          1: if (dt) begin m_st = 2; m_start = 1; end
          2: begin
            if (tx_req) begin m_start = 1; m_p = 0; end
            else if (pt) begin
              if (!buf_empty) m_p = 0;
              else if (fifo_empty && m_seen) begin m_p = 0; m_drain(); end
              else begin m_seen = fifo_empty; m_p = char_cycles(); end
            end else if (m_p == 0 && buf_empty) begin m_p = char_cycles(); m_seen = 0; end
          end
          default: begin
            if (tx_req && dt) m_begin();
            else if (tx_req) begin m_st = 2; m_start = 1; m_d = 0; end
            else if (dt) begin m_st = 0; m_de = de_after; end
          end
        endcase
      end
      m_en = en_i;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check("R2/R8 model de_o", de_o, m_de);
      check("R2/R4 model tx_start_o", tx_start_o, m_start);
      if (tx_start_o) starts++;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic pulse_req();
    tx_req = 1; @(negedge clk_i); tx_req = 0;
  endtask

  task automatic report();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    int s0;
    @(negedge clk_i);
    check("R1 de_o reset", de_o, 1'b0);
    check("R1 tx_start_o reset", tx_start_o, 1'b0);
    rst_ni = 1;
    wait_cyc(3);
    check("R1 de_o after release", de_o, 1'b0);
    en_i = 1;
    wait_cyc(100);
    check("R12 de_o after enable", de_o, 1'b0);

    // R2 with pre-send delay, R3 ignored request
    buf_empty = 0; fifo_empty = 0;
    s0 = starts;
    pulse_req();
    check("R2 de_o on-send level", de_o, 1'b1);
    wait_cyc(100);
    pulse_req();
    wait_cyc(60);
    check("R3 no early start", 1'(starts - s0), 1'b0);
    wait_cyc(60);
    check("R2 one start after delay", (starts - s0) == 1, 1'b1);
    check("R3 single start", (starts - s0) == 1, 1'b1);

    // R4 request while sending
    pulse_req();
    check("R4 restrobe", tx_start_o, 1'b1);
    check("R4 de_o unchanged", de_o, 1'b1);

    // R6 poll aborted by new data
    buf_empty = 1;
    wait_cyc(150);
    buf_empty = 0;
    wait_cyc(200);
    check("R6 abort keeps de_o", de_o, 1'b1);

    // R7 drain needs two empty ticks, R8 post-send delay
    buf_empty = 1;
    wait_cyc(250);
    fifo_empty = 1;
    wait_cyc(50);
    check("R7 no drain on first tick", de_o, 1'b1);
    wait_cyc(150);
    check("R8 post delay holds de_o", de_o, 1'b1);
    wait_cyc(250);
    check("R8 de_o after-send level", de_o, 1'b0);

    // R2 zero pre-send delay, R5 request in post-send delay
    pre_ms = 0;
    pulse_req();
    check("R2 zero delay start", tx_start_o, 1'b1);
    check("R2 zero delay de_o", de_o, 1'b1);
    wait_cyc(300);
    s0 = starts;
    pulse_req();
    check("R5 start from after", tx_start_o, 1'b1);
    check("R5 de_o kept", de_o, 1'b1);
    wait_cyc(700);
    check("R8 release after resend", de_o, 1'b0);

    // R8 zero post-send delay; 8N1 = 10 bits = 100 cycles
    post_ms = 0;
    pulse_req();
    wait_cyc(170);
    check("R8 de_o before drain", de_o, 1'b1);
    wait_cyc(40);
    check("R8 immediate release", de_o, 1'b0);

    // R9/R10 5 data bits + two stop + parity = 9 bits = 90 cycles
    dbits = 2'd0; two_stop = 1; par_en = 1;
    wait_cyc(100);
    pulse_req();
    wait_cyc(165);
    check("R10 9-bit before drain", de_o, 1'b1);
    wait_cyc(30);
    check("R9 9-bit drain at 180", de_o, 1'b0);
    // 6 data bits = 8 bits = 80 cycles
    dbits = 2'd1; two_stop = 0; par_en = 0;
    wait_cyc(100);
    pulse_req();
    wait_cyc(150);
    check("R10 8-bit before drain", de_o, 1'b1);
    wait_cyc(20);
    check("R9 8-bit drain at 160", de_o, 1'b0);

    // R11 disable during send
    buf_empty = 0; fifo_empty = 0;
    pulse_req();
    wait_cyc(5);
    en_i = 0;
    wait_cyc(1);
    check("R11 de_o forced low", de_o, 1'b0);
    pulse_req();
    check("R11 passthrough start", tx_start_o, 1'b1);
    check("R11 de_o stays low", de_o, 1'b0);

    // R12 enable with inverted polarity
    de_after = 1; de_on = 0; buf_empty = 1; fifo_empty = 1;
    en_i = 1;
    wait_cyc(2);
    check("R12 de_o after-send level", de_o, 1'b1);
    pulse_req();
    check("R2 inverted on-send level", de_o, 1'b0);
    wait_cyc(300);
    check("R8 inverted release", de_o, 1'b1);
    report();
  end
endmodule